// File: doc/BRIEF.md
# IN Endpoint Transmit Controller

This block answers IN tokens for a single device endpoint of a full-speed serial bus device. Firmware fills a small packet buffer, writes a byte count and a data-toggle bit, and then raises a ready flag. When the token decoder reports a valid IN token for this endpoint, the block produces one packet on a byte stream towards the packet encoder. If the endpoint is stalled, that packet is a STALL handshake. If firmware has not armed the endpoint, it is a NAK handshake. Otherwise it is a data packet: a DATA0 or DATA1 PID chosen by the toggle bit, followed by the counted bytes.

After a data packet the block waits for the host's handshake. An ACK clears the ready flag and raises an interrupt. If no ACK arrives within a bounded window, the ready flag stays set and the same bytes go out again on the next IN token. Firmware therefore learns whether a transfer succeeded by reading the ready flag.

The same RTL serves the control endpoint, which is always active, and a transmit-only endpoint, which responds only while its configured bit is set. The `NEED_CFG` parameter selects between the two. Serialization, CRC generation and token decoding belong to neighbouring blocks.

Top module: `in_ep_tx`

## Requirements
- R1: After reset `rdy_o`, `irq_o` and `tx_valid_o` are 0.
- R2: An accepted IN token while `stall_i` is high produces a single stream byte 8'h1E with `tx_last_o` set, and leaves `rdy_o` unchanged.
- R3: An accepted IN token while `stall_i` is low and `rdy_o` is 0 produces a single stream byte 8'h5A with `tx_last_o` set.
- R4: An accepted IN token while `stall_i` is low and `rdy_o` is 1 produces a PID byte, 8'hC3 when the toggle bit is 0 or 8'h4B when it is 1. The data bytes follow from buffer addresses 0 upward, and `tx_last_o` marks the final byte.
- R5: The number of data bytes equals the stored byte count. A written count above `DEPTH` is stored as `DEPTH`. A count of 0 yields only the PID byte, with `tx_last_o` set.
- R6: An ACK (`hs_ack_i`) received while the block waits for the handshake clears `rdy_o` and sets `irq_o` on the next cycle. `irq_o` then stays set until `irq_clr_i` is pulsed.
- R7: If no ACK arrives within `HS_TIMEOUT_BITS*CLKS_PER_BIT` cycles after the last data byte, the block returns to idle with `rdy_o` still 1, and the next IN token sends the same data again.
- R8: An ACK that arrives while no handshake is awaited changes neither `rdy_o` nor `irq_o`.
- R9: With `NEED_CFG`=1 and `cfg_en_i` low, IN tokens produce no stream output and leave `rdy_o` unchanged.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o` and `tx_last_o` hold their values on the next cycle.
- R11: `tx_last_o` is never high while `tx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Endpoint configured (used only when NEED_CFG=1) |
| stall_i | input | 1 | Endpoint stall control |
| buf_we_i | input | 1 | Packet buffer write strobe |
| buf_waddr_i | input | AW | Packet buffer write address |
| buf_wdata_i | input | 8 | Packet buffer write data |
| cnt_we_i | input | 1 | Byte count write strobe |
| cnt_wdata_i | input | CNT_W | Byte count value |
| tgl_we_i | input | 1 | Toggle bit write strobe |
| tgl_wdata_i | input | 1 | Toggle bit value (0 selects DATA0, 1 selects DATA1) |
| rdy_set_i | input | 1 | Sets the ready flag |
| irq_clr_i | input | 1 | Clears the transmit interrupt |
| rdy_o | output | 1 | Ready flag |
| irq_o | output | 1 | Transmit-complete interrupt |
| in_tok_i | input | 1 | Valid IN token for this endpoint, one-cycle pulse |
| hs_ack_i | input | 1 | Host ACK received, one-cycle pulse |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of the packet |
| tx_ready_i | input | 1 | Encoder accepts the byte |

## Verification
The bench builds the block with `NEED_CFG`=1, `DEPTH`=8, `CLKS_PER_BIT`=2 and `HS_TIMEOUT_BITS`=16. These values make the configured-bit gate observable and bring a full-buffer packet within a few cycles. They also put the count clamp within reach with a 4-bit count, and they shorten the handshake window to 32 cycles, so the timeout and resend path runs quickly. The encoder ready is throttled in a repeating pattern throughout, which keeps the hold-under-backpressure rule active on PID, data and handshake bytes.

// File: rtl/in_ep_tx_pkg.sv
package in_ep_tx_pkg;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam logic [7:0] PID_STALL = 8'h1E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PID,
    ST_DATA,
    ST_WAIT,
    ST_HSK
  } tx_state_e;
endpackage

// File: rtl/in_ep_buf.sv
module in_ep_buf #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/in_ep_hs_timer.sv
module in_ep_hs_timer #(
  parameter int LIMIT = 64,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + TW'(1);
  end

  assign expire_o = run_i && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/in_ep_regs.sv
module in_ep_regs #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             tgl_we_i,
  input  logic             tgl_wdata_i,
  input  logic             rdy_set_i,
  input  logic             irq_clr_i,
  input  logic             ack_done_i,
  output logic             rdy_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tgl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o <= 1'b0;
      irq_o <= 1'b0;
      cnt_o <= '0;
      tgl_o <= 1'b0;
    end else begin
      if (cnt_we_i)
        cnt_o <= (cnt_wdata_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cnt_wdata_i;
      if (tgl_we_i) tgl_o <= tgl_wdata_i;
      // a fresh arm from firmware wins over a same-cycle ACK
      if (ack_done_i) rdy_o <= 1'b0;
      if (rdy_set_i)  rdy_o <= 1'b1;
      if (irq_clr_i)  irq_o <= 1'b0;
      if (ack_done_i) irq_o <= 1'b1;
    end
  end
endmodule

// File: rtl/in_ep_fsm.sv
module in_ep_fsm
  import in_ep_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_i,
  input  logic             stall_i,
  input  logic             rdy_i,
  input  logic             tgl_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ack_i,
  input  logic             expire_i,
  input  logic [7:0]       rdata_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  output logic [AW-1:0]    raddr_o,
  output logic             wait_o,
  output logic             ack_done_o
);
  tx_state_e        state_q;
  logic [7:0]       pid_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] idx_q;
  logic             data_end;

  assign data_end = (idx_q + CNT_W'(1)) == len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pid_q   <= PID_NAK;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (tok_i) begin
          if (stall_i) begin
            pid_q   <= PID_STALL;
            state_q <= ST_HSK;
          end else if (!rdy_i) begin
            pid_q   <= PID_NAK;
            state_q <= ST_HSK;
          end else begin
            pid_q   <= tgl_i ? PID_DATA1 : PID_DATA0;
            len_q   <= cnt_i;
            idx_q   <= '0;
            state_q <= ST_PID;
          end
        end
        ST_PID: if (tx_ready_i) state_q <= (len_q == '0) ? ST_WAIT : ST_DATA;
        ST_DATA: if (tx_ready_i) begin
          if (data_end) state_q <= ST_WAIT;
          else          idx_q   <= idx_q + CNT_W'(1);
        end
        ST_WAIT: if (ack_i || expire_i) state_q <= ST_IDLE;
        ST_HSK:  if (tx_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid_o = (state_q == ST_PID) || (state_q == ST_DATA) || (state_q == ST_HSK);
  assign tx_data_o  = (state_q == ST_DATA) ? rdata_i : pid_q;
  assign tx_last_o  = (state_q == ST_HSK)
                   || ((state_q == ST_PID) && (len_q == '0))
                   || ((state_q == ST_DATA) && data_end);
  assign raddr_o    = idx_q[AW-1:0];
  assign wait_o     = state_q == ST_WAIT;
  assign ack_done_o = wait_o && ack_i;
endmodule

// File: rtl/in_ep_tx.sv
module in_ep_tx #(
  parameter int DEPTH           = 64,
  parameter int CLKS_PER_BIT    = 4,
  parameter int HS_TIMEOUT_BITS = 16,
  parameter bit NEED_CFG        = 1'b0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             stall_i,
  input  logic             buf_we_i,
  input  logic [AW-1:0]    buf_waddr_i,
  input  logic [7:0]       buf_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             tgl_we_i,
  input  logic             tgl_wdata_i,
  input  logic             rdy_set_i,
  input  logic             irq_clr_i,
  output logic             rdy_o,
  output logic             irq_o,
  input  logic             in_tok_i,
  input  logic             hs_ack_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  input  logic             tx_ready_i
);
  localparam int HS_LIMIT = CLKS_PER_BIT * HS_TIMEOUT_BITS;

  logic             tok_gated;
  logic             wait_hs;
  logic             expire;
  logic             ack_done;
  logic             tgl;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    raddr;
  logic [7:0]       rdata;

  generate
    if (NEED_CFG) begin : g_cfg_gate
      assign tok_gated = in_tok_i & cfg_en_i;
    end else begin : g_always_on
      assign tok_gated = in_tok_i & (cfg_en_i | 1'b1);
    end
  endgenerate

  in_ep_buf #(.DEPTH(DEPTH)) i_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we_i),
    .waddr_i (buf_waddr_i),
    .wdata_i (buf_wdata_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  in_ep_regs #(.DEPTH(DEPTH)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_we_i    (cnt_we_i),
    .cnt_wdata_i (cnt_wdata_i),
    .tgl_we_i    (tgl_we_i),
    .tgl_wdata_i (tgl_wdata_i),
    .rdy_set_i   (rdy_set_i),
    .irq_clr_i   (irq_clr_i),
    .ack_done_i  (ack_done),
    .rdy_o       (rdy_o),
    .irq_o       (irq_o),
    .cnt_o       (cnt),
    .tgl_o       (tgl)
  );

  in_ep_hs_timer #(.LIMIT(HS_LIMIT)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wait_hs),
    .expire_o (expire)
  );

  in_ep_fsm #(.DEPTH(DEPTH)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tok_i      (tok_gated),
    .stall_i    (stall_i),
    .rdy_i      (rdy_o),
    .tgl_i      (tgl),
    .cnt_i      (cnt),
    .ack_i      (hs_ack_i),
    .expire_i   (expire),
    .rdata_i    (rdata),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o),
    .raddr_o    (raddr),
    .wait_o     (wait_hs),
    .ack_done_o (ack_done)
  );
endmodule

// File: rtl/in_ep_tx_chk.sv
module in_ep_tx_chk #(
  parameter bit NEED_CFG = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_en_i,
  input logic       stall_i,
  input logic       rdy_set_i,
  input logic       irq_clr_i,
  input logic       rdy_o,
  input logic       irq_o,
  input logic       in_tok_i,
  input logic       hs_ack_i,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_last_o,
  input logic       tx_ready_i,
  input logic       wait_hs
);
  logic cfg_ok;
  logic idle;
  assign cfg_ok = !NEED_CFG || cfg_en_i;
  assign idle   = !tx_valid_o && !wait_hs;

  p_stall_reply_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i && cfg_ok && idle && stall_i |=> tx_valid_o && tx_last_o && tx_data_o == 8'h1E);

  p_nak_reply_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i && cfg_ok && idle && !stall_i && !rdy_o |=> tx_valid_o && tx_last_o && tx_data_o == 8'h5A);

  p_data_pid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i && cfg_ok && idle && !stall_i && rdy_o |=> tx_valid_o && (tx_data_o == 8'hC3 || tx_data_o == 8'h4B));

  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_hs && hs_ack_i && !rdy_set_i |=> !rdy_o && irq_o);

  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  p_stray_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_ack_i && !wait_hs && !rdy_set_i && !irq_clr_i |=> rdy_o == $past(rdy_o) && irq_o == $past(irq_o));

  p_unconfigured_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    NEED_CFG && !cfg_en_i && idle |=> !tx_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  p_last_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
endmodule

bind in_ep_tx in_ep_tx_chk #(.NEED_CFG(NEED_CFG)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en_i),
  .stall_i    (stall_i),
  .rdy_set_i  (rdy_set_i),
  .irq_clr_i  (irq_clr_i),
  .rdy_o      (rdy_o),
  .irq_o      (irq_o),
  .in_tok_i   (in_tok_i),
  .hs_ack_i   (hs_ack_i),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_last_o  (tx_last_o),
  .tx_ready_i (tx_ready_i),
  .wait_hs    (wait_hs)
);

// File: tb/test_in_ep_tx.sv
module test_in_ep_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int CPB        = 2;
  localparam int HS_BITS    = 16;
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int AW         = $clog2(DEPTH);
  localparam int HS_LIMIT   = CPB * HS_BITS;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             tgl;
    logic             stall;
    logic             set_rdy;
    logic             ack;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd0,  1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd8,  1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd8,  1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd2,  1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd5,  1'b1, 1'b1, 1'b1, 1'b0},
    '{4'd5,  1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd12, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_en = 1'b1;
  logic             stall = 1'b0;
  logic             buf_we = 1'b0;
  logic [AW-1:0]    buf_waddr = '0;
  logic [7:0]       buf_wdata = '0;
  logic             cnt_we = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic             tgl_we = 1'b0;
  logic             tgl_wdata = 1'b0;
  logic             rdy_set = 1'b0;
  logic             irq_clr = 1'b0;
  logic             rdy, irq;
  logic             in_tok = 1'b0;
  logic             hs_ack = 1'b0;
  logic             tx_valid, tx_last;
  logic [7:0]       tx_data;
  logic             tx_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  in_ep_tx #(
    .DEPTH(DEPTH), .CLKS_PER_BIT(CPB), .HS_TIMEOUT_BITS(HS_BITS), .NEED_CFG(1'b1)
  ) i_in_ep_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .stall_i(stall),
    .buf_we_i(buf_we), .buf_waddr_i(buf_waddr), .buf_wdata_i(buf_wdata),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata), .tgl_we_i(tgl_we), .tgl_wdata_i(tgl_wdata),
    .rdy_set_i(rdy_set), .irq_clr_i(irq_clr), .rdy_o(rdy), .irq_o(irq),
    .in_tok_i(in_tok), .hs_ack_i(hs_ack), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  function automatic logic [7:0] pattern(int i);
    return 8'h30 + 8'(i * 7);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tok();
    @(negedge clk); in_tok = 1'b1;
    @(negedge clk); in_tok = 1'b0;
  endtask

  // collects one packet with throttled ready; returns pid and number of data bytes
  task automatic collect(output logic [7:0] pid, output int nbytes, output bit got_last);
    int n = 0;
    logic [7:0] prev_data = '0;
    bit stalled = 1'b0;
    got_last = 1'b0;
    pid = 8'h00;
    for (int k = 0; k < 100 && !got_last; k++) begin
      @(negedge clk);
      if (stalled) chk(tx_valid && tx_data == prev_data, "R10", tx_data, prev_data);
      tx_ready = (k % 3) != 2;
      if (tx_last) chk(tx_valid, "R11", tx_valid, 1);
      stalled = tx_valid && !tx_ready;
      prev_data = tx_data;
      if (tx_valid && tx_ready) begin
        if (n == 0) pid = tx_data;
        else chk(tx_data == pattern(n - 1), "R4 data", tx_data, pattern(n - 1));
        n++;
        got_last = tx_last;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    nbytes = n - 1;
  endtask

  task automatic fw_pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pid;
    int nbytes;
    bit got_last;
    bit rdy_m = 1'b0;

    repeat (3) @(negedge clk);
    chk(!rdy && !irq && !tx_valid, "R1 reset", {rdy, irq, tx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rdy && !irq && !tx_valid, "R1 after release", {rdy, irq, tx_valid}, 0);

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_waddr = AW'(i); buf_wdata = pattern(i);
    end
    @(negedge clk); buf_we = 1'b0;

    foreach (VECS[v]) begin
      int exp_n;
      logic [7:0] exp_pid;
      bit is_data;
      @(negedge clk);
      cnt_we = 1'b1; cnt_wdata = VECS[v].cnt;
      tgl_we = 1'b1; tgl_wdata = VECS[v].tgl;
      stall = VECS[v].stall;
      rdy_set = VECS[v].set_rdy;
      irq_clr = 1'b1;
      @(negedge clk);
      cnt_we = 1'b0; tgl_we = 1'b0; rdy_set = 1'b0; irq_clr = 1'b0;
      rdy_m = rdy_m | VECS[v].set_rdy;

      is_data = !VECS[v].stall && rdy_m;
      exp_pid = VECS[v].stall ? 8'h1E : !rdy_m ? 8'h5A : VECS[v].tgl ? 8'h4B : 8'hC3;
      exp_n = !is_data ? 0 : (int'(VECS[v].cnt) > DEPTH) ? DEPTH : int'(VECS[v].cnt);

      pulse_tok();
      collect(pid, nbytes, got_last);
      chk(got_last, "R4 packet ends with last", got_last, 1);
      if (VECS[v].stall)   chk(pid == exp_pid, "R2 stall pid", pid, exp_pid);
      else if (!is_data)   chk(pid == exp_pid, "R3 nak pid", pid, exp_pid);
      else                 chk(pid == exp_pid, "R4 data pid", pid, exp_pid);
      chk(nbytes == exp_n, "R5 byte count", nbytes, exp_n);

      if (is_data && VECS[v].ack) begin
        hs_ack = 1'b1;
        @(negedge clk);
        hs_ack = 1'b0;
        chk(!rdy && irq, "R6 ack clears ready, raises irq", {rdy, irq}, 2'b01);
        repeat (3) @(negedge clk);
        chk(irq, "R6 irq held", irq, 1);
        rdy_m = 1'b0;
      end else if (is_data) begin
        repeat (HS_LIMIT + 4) @(negedge clk);
        chk(rdy && !tx_valid, "R7 timeout keeps ready", {rdy, tx_valid}, 2'b10);
      end else begin
        chk(rdy == rdy_m, VECS[v].stall ? "R2 ready unchanged" : "R3 ready unchanged", rdy, rdy_m);
      end
    end

    fw_pulse(irq_clr);
    @(negedge clk);
    chk(!irq, "R6 irq cleared", irq, 0);

    // stray ACK in idle with ready armed
    fw_pulse(rdy_set);
    fw_pulse(hs_ack);
    @(negedge clk);
    chk(rdy && !irq, "R8 stray ack ignored", {rdy, irq}, 2'b10);

    // unconfigured endpoint ignores tokens
    @(negedge clk); cfg_en = 1'b0; tx_ready = 1'b1;
    pulse_tok();
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (tx_valid) seen = 1'b1;
      end
      chk(!seen, "R9 no response when unconfigured", seen, 0);
    end
    chk(rdy, "R9 ready unchanged", rdy, 1);
    tx_ready = 1'b0;
    cfg_en = 1'b1;

    // once configured the armed data goes out
    pulse_tok();
    collect(pid, nbytes, got_last);
    chk(pid == 8'hC3, "R9 configured again responds", pid, 8'hC3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule